// File: doc/BRIEF.md
# Tagged-Word Register and Memory Executor

This block is a tiny single-cycle execution unit. It owns a small register file and a small data memory, and every word in both carries a 2-bit type tag that classes it as zero, plain data, or an address. One instruction is taken per cycle when `in_valid` is high. The four instructions are move-immediate, register-to-register move, load and store. Loads and stores use a pointer register, and they only reach memory when that register is tagged as an address whose payload falls inside the memory.

Any other pointer, an undefined opcode, or an immediate with the reserved tag is refused. A refused instruction changes no register and no memory word. It sets an exception flag that stays set until reset. An undefined instruction also raises a one-cycle illegal-instruction pulse. Debug ports read any register and any memory word combinationally, so a test or a monitor can see the full architectural state.

Top module: `tagexec_core`

## Requirements
- R1: After reset, every register and every memory word reads tag 00 (zero) with payload 0, `exc_o` and `illegal_o` are low, and `in_ready` is high.
- R2: Move-immediate (opcode 000) writes `{in_imm_tag, in_imm_val}` into register `in_rd` and leaves memory and `exc_o` unchanged. The tag is 00 for zero, 01 for data and 10 for address.
- R3: Register move (opcode 001) copies both the tag and the payload of register `in_rs` into register `in_rd`.
- R4: Load (opcode 010) with register `in_rs` tagged 10 and a payload below `MEM_DEPTH` writes the memory word at that payload into register `in_rd`, and leaves memory unchanged.
- R5: Store (opcode 011) with register `in_rs` tagged 10 and a payload below `MEM_DEPTH` writes register `in_rd`, tag included, into memory at that payload, and leaves the registers unchanged.
- R6: A load or store whose pointer register is tagged 00 or 01 sets `exc_o` in the next cycle and changes no register and no memory word.
- R7: A load or store whose pointer register is tagged 10 but whose payload is at least `MEM_DEPTH` traps exactly as in R6.
- R8: Opcodes 100 to 111, and move-immediate with tag 11, are illegal. They drive `illegal_o` high for exactly the one cycle after acceptance, set `exc_o`, and change no state.
- R9: `exc_o` stays high until reset, and instructions accepted while it is high still execute normally.
- R10: A cycle with `in_valid` low changes no register, no memory word and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_ready | output | 1 | Unit can accept an instruction (high out of reset) |
| in_op | input | 3 | Opcode |
| in_rd | input | REG_IDX_W | Target register (move-immediate, move, load) or source register (store) |
| in_rs | input | REG_IDX_W | Source register (move) or pointer register (load, store) |
| in_imm_tag | input | 2 | Tag of the immediate |
| in_imm_val | input | DATA_W | Payload of the immediate |
| dbg_reg_idx | input | REG_IDX_W | Register selected for debug read |
| dbg_reg_tag | output | 2 | Tag of the selected register |
| dbg_reg_val | output | DATA_W | Payload of the selected register |
| dbg_mem_idx | input | MEM_IDX_W | Memory word selected for debug read |
| dbg_mem_tag | output | 2 | Tag of the selected memory word |
| dbg_mem_val | output | DATA_W | Payload of the selected memory word |
| exc_o | output | 1 | Sticky exception flag |
| illegal_o | output | 1 | One-cycle pulse after an illegal instruction |

## Verification
Every instruction commits on a single edge, and the debug ports read state with no register in the path. A wrong write enable, a wrong mux select or a wrong tag therefore shows on `dbg_reg_*` or `dbg_mem_*` in the same half-cycle that follows the accepting edge. A missed trap shows at the same point in two ways: `exc_o` stays low, and a register or memory word that should not have changed now reads differently. A pointer that is out of range but silently truncated shows up as a write to a low memory word.

// File: rtl/tagexec_pkg.sv
package tagexec_pkg;

    typedef enum logic [1:0] {
        TAG_ZERO = 2'b00,
        TAG_DATA = 2'b01,
        TAG_ADDR = 2'b10,
        TAG_RSVD = 2'b11
    } tag_e;

    localparam logic [2:0] OP_MOVI  = 3'b000;
    localparam logic [2:0] OP_MOV   = 3'b001;
    localparam logic [2:0] OP_LOAD  = 3'b010;
    localparam logic [2:0] OP_STORE = 3'b011;

    typedef enum logic [1:0] {
        SRC_IMM = 2'b00,
        SRC_REG = 2'b01,
        SRC_MEM = 2'b10
    } src_e;

    typedef struct packed {
        logic reg_we;
        logic mem_we;
        src_e src_sel;
        logic trap;
        logic illegal;
    } ctl_t;

    typedef struct packed {
        logic exc;
        logic ill;
    } stat_t;

endpackage

// File: rtl/tagexec_bank.sv
module tagexec_bank #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 10,
    parameter int NUM_RD = 2,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              waddr,
    input  logic [WORD_W-1:0]             wdata,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] words_d [DEPTH];
    logic [WORD_W-1:0] words_q [DEPTH];

    always_comb begin
        words_d = words_q;
        if (we) begin
            words_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '{default: '0};
        end else begin
            words_q <= words_d;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data[p] = words_q[rd_idx[p]];
    end

    // R2 / R5: a committed write is visible at its address on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> words_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/tagexec_decode.sv
module tagexec_decode
    import tagexec_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 16
) (
    input  logic              fire,
    input  logic [2:0]        op,
    input  logic [1:0]        imm_tag,
    input  logic [1:0]        ptr_tag,
    input  logic [DATA_W-1:0] ptr_val,
    output ctl_t              ctl
);

    localparam logic [DATA_W:0] DEPTH_LIM = MEM_DEPTH[DATA_W:0];

    logic ptr_ok;

    always_comb begin
        ptr_ok = (ptr_tag == TAG_ADDR) && ({1'b0, ptr_val} < DEPTH_LIM);
        ctl    = '{reg_we: 1'b0, mem_we: 1'b0, src_sel: SRC_IMM,
                   trap: 1'b0, illegal: 1'b0};
        if (fire) begin
            unique case (op)
                OP_MOVI: begin
                    if (imm_tag == TAG_RSVD) ctl.illegal = 1'b1;
                    else                     ctl.reg_we  = 1'b1;
                end
                OP_MOV: begin
                    ctl.reg_we  = 1'b1;
                    ctl.src_sel = SRC_REG;
                end
                OP_LOAD: begin
                    ctl.src_sel = SRC_MEM;
                    ctl.reg_we  = ptr_ok;
                    ctl.trap    = !ptr_ok;
                end
                OP_STORE: begin
                    ctl.mem_we = ptr_ok;
                    ctl.trap   = !ptr_ok;
                end
                default: ctl.illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/tagexec_core.sv
module tagexec_core
    import tagexec_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 4,
    parameter int MEM_DEPTH = 16,
    parameter int REG_IDX_W = $clog2(NUM_REGS),
    parameter int MEM_IDX_W = $clog2(MEM_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_op,
    input  logic [REG_IDX_W-1:0] in_rd,
    input  logic [REG_IDX_W-1:0] in_rs,
    input  logic [1:0]           in_imm_tag,
    input  logic [DATA_W-1:0]    in_imm_val,
    input  logic [REG_IDX_W-1:0] dbg_reg_idx,
    output logic [1:0]           dbg_reg_tag,
    output logic [DATA_W-1:0]    dbg_reg_val,
    input  logic [MEM_IDX_W-1:0] dbg_mem_idx,
    output logic [1:0]           dbg_mem_tag,
    output logic [DATA_W-1:0]    dbg_mem_val,
    output logic                 exc_o,
    output logic                 illegal_o
);

    localparam int WORD_W = DATA_W + 2;
    localparam logic [DATA_W:0] DEPTH_LIM = MEM_DEPTH[DATA_W:0];

    logic                              fire;
    ctl_t                              ctl;
    logic [2:0][REG_IDX_W-1:0]         reg_ridx;
    logic [2:0][WORD_W-1:0]            reg_rdata;
    logic [1:0][MEM_IDX_W-1:0]         mem_ridx;
    logic [1:0][WORD_W-1:0]            mem_rdata;
    logic [WORD_W-1:0]                 ptr_word;
    logic [WORD_W-1:0]                 reg_wdata;
    stat_t                             st_d, st_q;

    assign in_ready = rst_n;
    assign fire     = in_valid && in_ready;

    // read port 0: move source / pointer, 1: store source, 2: debug
    assign reg_ridx = {dbg_reg_idx, in_rd, in_rs};
    assign ptr_word = reg_rdata[0];
    assign mem_ridx = {dbg_mem_idx, ptr_word[MEM_IDX_W-1:0]};

    tagexec_decode #(
        .DATA_W    (DATA_W),
        .MEM_DEPTH (MEM_DEPTH)
    ) decode_i (
        .fire    (fire),
        .op      (in_op),
        .imm_tag (in_imm_tag),
        .ptr_tag (ptr_word[WORD_W-1 -: 2]),
        .ptr_val (ptr_word[DATA_W-1:0]),
        .ctl     (ctl)
    );

    always_comb begin
        unique case (ctl.src_sel)
            SRC_REG: reg_wdata = reg_rdata[0];
            SRC_MEM: reg_wdata = mem_rdata[0];
            default: reg_wdata = {in_imm_tag, in_imm_val};
        endcase
    end

    tagexec_bank #(
        .DEPTH  (NUM_REGS),
        .WORD_W (WORD_W),
        .NUM_RD (3),
        .IDX_W  (REG_IDX_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.reg_we),
        .waddr   (in_rd),
        .wdata   (reg_wdata),
        .rd_idx  (reg_ridx),
        .rd_data (reg_rdata)
    );

    tagexec_bank #(
        .DEPTH  (MEM_DEPTH),
        .WORD_W (WORD_W),
        .NUM_RD (2),
        .IDX_W  (MEM_IDX_W)
    ) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.mem_we),
        .waddr   (ptr_word[MEM_IDX_W-1:0]),
        .wdata   (reg_rdata[1]),
        .rd_idx  (mem_ridx),
        .rd_data (mem_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.exc = st_q.exc | ctl.trap | ctl.illegal;
        st_d.ill = ctl.illegal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exc_o       = st_q.exc;
    assign illegal_o   = st_q.ill;
    assign dbg_reg_tag = reg_rdata[2][WORD_W-1 -: 2];
    assign dbg_reg_val = reg_rdata[2][DATA_W-1:0];
    assign dbg_mem_tag = mem_rdata[1][WORD_W-1 -: 2];
    assign dbg_mem_val = mem_rdata[1][DATA_W-1:0];

    // R6: a non-address pointer never lets a load or store write anything
    assert_trap_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_LOAD || in_op == OP_STORE)
         && ptr_word[WORD_W-1 -: 2] != TAG_ADDR) |-> !ctl.reg_we && !ctl.mem_we);

    // R7: an address payload beyond the memory raises the flag
    assert_range_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_LOAD || in_op == OP_STORE)
         && {1'b0, ptr_word[DATA_W-1:0]} >= DEPTH_LIM) |=> exc_o);

    // R8: the illegal pulse always comes with the exception flag
    assert_illegal_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> exc_o);

    // R9: the exception flag never clears without reset
    assert_exc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |=> exc_o);

    // R10: an idle cycle writes nothing
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !ctl.reg_we && !ctl.mem_we && !ctl.trap && !ctl.illegal);

endmodule

// File: tb/tagexec_core_tb.sv
module tagexec_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] TZ = 2'b00;
    localparam logic [1:0] TD = 2'b01;
    localparam logic [1:0] TA = 2'b10;
    localparam logic [1:0] TR = 2'b11;

    typedef struct packed {
        logic [2:0] op;
        logic [1:0] rd;
        logic [1:0] rs;
        logic [1:0] itag;
        logic [7:0] ival;
        logic [1:0] creg;
        logic [1:0] rtag;
        logic [7:0] rval;
        logic [3:0] cmem;
        logic [1:0] mtag;
        logic [7:0] mval;
        logic       exc;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 2'd0, 2'd0, TA, 8'h05, 2'd0, TA, 8'h05, 4'd5,  TZ, 8'h00, 1'b0},
        '{3'd0, 2'd1, 2'd0, TD, 8'h3C, 2'd1, TD, 8'h3C, 4'd5,  TZ, 8'h00, 1'b0},
        '{3'd3, 2'd1, 2'd0, TZ, 8'h00, 2'd1, TD, 8'h3C, 4'd5,  TD, 8'h3C, 1'b0},
        '{3'd2, 2'd2, 2'd0, TZ, 8'h00, 2'd2, TD, 8'h3C, 4'd5,  TD, 8'h3C, 1'b0},
        '{3'd1, 2'd3, 2'd0, TZ, 8'h00, 2'd3, TA, 8'h05, 4'd5,  TD, 8'h3C, 1'b0},
        '{3'd3, 2'd3, 2'd0, TZ, 8'h00, 2'd3, TA, 8'h05, 4'd5,  TA, 8'h05, 1'b0},
        '{3'd2, 2'd2, 2'd0, TZ, 8'h00, 2'd2, TA, 8'h05, 4'd5,  TA, 8'h05, 1'b0},
        '{3'd0, 2'd1, 2'd0, TZ, 8'h00, 2'd1, TZ, 8'h00, 4'd5,  TA, 8'h05, 1'b0},
        '{3'd2, 2'd3, 2'd2, TZ, 8'h00, 2'd3, TA, 8'h05, 4'd5,  TA, 8'h05, 1'b0},
        '{3'd0, 2'd1, 2'd0, TD, 8'hFF, 2'd1, TD, 8'hFF, 4'd15, TZ, 8'h00, 1'b0},
        '{3'd0, 2'd2, 2'd0, TA, 8'h0F, 2'd2, TA, 8'h0F, 4'd15, TZ, 8'h00, 1'b0},
        '{3'd3, 2'd1, 2'd2, TZ, 8'h00, 2'd1, TD, 8'hFF, 4'd15, TD, 8'hFF, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_op = '0;
    logic [1:0] in_rd = '0;
    logic [1:0] in_rs = '0;
    logic [1:0] in_imm_tag = '0;
    logic [7:0] in_imm_val = '0;
    logic [1:0] dbg_reg_idx = '0;
    logic [1:0] dbg_reg_tag;
    logic [7:0] dbg_reg_val;
    logic [3:0] dbg_mem_idx = '0;
    logic [1:0] dbg_mem_tag;
    logic [7:0] dbg_mem_val;
    logic       exc_o;
    logic       illegal_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tagexec_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_op       (in_op),
        .in_rd       (in_rd),
        .in_rs       (in_rs),
        .in_imm_tag  (in_imm_tag),
        .in_imm_val  (in_imm_val),
        .dbg_reg_idx (dbg_reg_idx),
        .dbg_reg_tag (dbg_reg_tag),
        .dbg_reg_val (dbg_reg_val),
        .dbg_mem_idx (dbg_mem_idx),
        .dbg_mem_tag (dbg_mem_tag),
        .dbg_mem_val (dbg_mem_val),
        .exc_o       (exc_o),
        .illegal_o   (illegal_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [1:0] idx,
                           input logic [1:0] tag, input logic [7:0] val);
        dbg_reg_idx = idx;
        #1;
        chk(req, {22'd0, dbg_reg_tag, dbg_reg_val}, {22'd0, tag, val});
    endtask

    task automatic chk_mem(input string req, input logic [3:0] idx,
                           input logic [1:0] tag, input logic [7:0] val);
        dbg_mem_idx = idx;
        #1;
        chk(req, {22'd0, dbg_mem_tag, dbg_mem_val}, {22'd0, tag, val});
    endtask

    // drive at the falling edge, commit at the rising edge, return at the next falling edge
    task automatic exec(input logic [2:0] op, input logic [1:0] rd, input logic [1:0] rs,
                        input logic [1:0] itag, input logic [7:0] ival, input logic vld);
        in_op = op; in_rd = rd; in_rs = rs; in_imm_tag = itag; in_imm_val = ival;
        in_valid = vld;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        for (int r = 0; r < 4; r++) chk_reg("R1 reg", 2'(r), TZ, 8'h00);
        for (int m = 0; m < 16; m++) chk_mem("R1 mem", 4'(m), TZ, 8'h00);
        chk("R1 exc", {31'd0, exc_o}, 32'd0);
        chk("R1 illegal", {31'd0, illegal_o}, 32'd0);
        chk("R1 ready", {31'd0, in_ready}, 32'd1);

        // R2 R3 R4 R5: vector table
        for (int v = 0; v < NVEC; v++) begin
            string tagname;
            exec(VECS[v].op, VECS[v].rd, VECS[v].rs, VECS[v].itag, VECS[v].ival, 1'b1);
            case (VECS[v].op)
                3'd0:    tagname = "R2 movi";
                3'd1:    tagname = "R3 mov";
                3'd2:    tagname = "R4 load";
                default: tagname = "R5 store";
            endcase
            chk_reg(tagname, VECS[v].creg, VECS[v].rtag, VECS[v].rval);
            chk_mem(tagname, VECS[v].cmem, VECS[v].mtag, VECS[v].mval);
            chk({tagname, " exc"}, {31'd0, exc_o}, {31'd0, VECS[v].exc});
        end

        // R10: idle cycle with a move-immediate on the bus
        exec(3'd0, 2'd0, 2'd0, TD, 8'h77, 1'b0);
        chk_reg("R10 idle reg", 2'd0, TA, 8'h05);
        chk("R10 idle exc", {31'd0, exc_o}, 32'd0);

        // R6: store through a data-tagged pointer (r1 = data FF)
        exec(3'd3, 2'd0, 2'd1, TZ, 8'h00, 1'b1);
        chk("R6 exc", {31'd0, exc_o}, 32'd1);
        chk("R6 no illegal", {31'd0, illegal_o}, 32'd0);
        chk_mem("R6 mem15", 4'd15, TD, 8'hFF);
        chk_mem("R6 mem5", 4'd5, TA, 8'h05);
        chk_reg("R6 reg0", 2'd0, TA, 8'h05);
        // R6: load through a zero-tagged pointer
        exec(3'd0, 2'd3, 2'd0, TZ, 8'h00, 1'b1);
        exec(3'd2, 2'd0, 2'd3, TZ, 8'h00, 1'b1);
        chk_reg("R6 load reg0", 2'd0, TA, 8'h05);

        // R9: flag stays, execution continues
        exec(3'd0, 2'd0, 2'd0, TD, 8'h11, 1'b1);
        chk_reg("R9 exec after exc", 2'd0, TD, 8'h11);
        chk("R9 sticky", {31'd0, exc_o}, 32'd1);
        exec(3'd2, 2'd1, 2'd2, TZ, 8'h00, 1'b1);
        chk_reg("R9 load after exc", 2'd1, TD, 8'hFF);
        do_reset();
        chk("R9 cleared by reset", {31'd0, exc_o}, 32'd0);
        chk_reg("R1 reg after reset", 2'd0, TZ, 8'h00);

        // R7: address tag, payload 16 is outside a 16-word memory
        exec(3'd0, 2'd0, 2'd0, TA, 8'h10, 1'b1);
        exec(3'd0, 2'd1, 2'd0, TD, 8'h99, 1'b1);
        chk("R7 no exc yet", {31'd0, exc_o}, 32'd0);
        exec(3'd3, 2'd1, 2'd0, TZ, 8'h00, 1'b1);
        chk("R7 store exc", {31'd0, exc_o}, 32'd1);
        chk_mem("R7 mem0 untouched", 4'd0, TZ, 8'h00);
        exec(3'd2, 2'd1, 2'd0, TZ, 8'h00, 1'b1);
        chk_reg("R7 load reg1", 2'd1, TD, 8'h99);

        // R8: undefined opcode
        do_reset();
        exec(3'd5, 2'd0, 2'd0, TD, 8'h44, 1'b1);
        chk("R8 illegal pulse", {31'd0, illegal_o}, 32'd1);
        chk("R8 exc", {31'd0, exc_o}, 32'd1);
        chk_reg("R8 reg0", 2'd0, TZ, 8'h00);
        exec(3'd0, 2'd0, 2'd0, TZ, 8'h00, 1'b0);
        chk("R8 pulse ends", {31'd0, illegal_o}, 32'd0);
        // R8: reserved immediate tag
        do_reset();
        exec(3'd0, 2'd2, 2'd0, TR, 8'h21, 1'b1);
        chk("R8 rsvd tag illegal", {31'd0, illegal_o}, 32'd1);
        chk_reg("R8 rsvd tag reg2", 2'd2, TZ, 8'h00);
        exec(3'd7, 2'd0, 2'd0, TZ, 8'h00, 1'b1);
        chk("R8 opcode 7", {31'd0, illegal_o}, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule